// File: doc/BRIEF.md
# Pseudo-SRAM Command Mode and Reset Tracker

This block follows the command stream of a serial/quad pseudo-SRAM and keeps its interface state. Each time the chip select falls, the pin-level shifter presents the 8-bit command it captured, together with a one-cycle valid strobe. The tracker decodes that byte and keeps two state bits. The first says whether the interface runs in serial or quad mode. The second says whether bursts are linear or wrap within 32 bytes.

Software reset uses two steps. A reset-enable command arms the tracker. A reset command that arrives as the very next command then fires a one-cycle reset pulse and returns the state to serial mode with linear bursts. After a reset, an internal counter blocks every new command for a parameterised number of clock cycles. A one-cycle acknowledge marks each command the tracker took.

Top module: `psram_cmd_tracker`

## Requirements
- R1: While `rst_n` is low and right after it rises, `quad_mode`, `wrap_mode`, `cmd_ack` and `soft_rst` are all 0. This is serial mode with linear bursts.
- R2: `cmd_ack` is 1 for exactly the cycle after a clock edge where `cmd_vld` was 1 and no quiet window was running. In every other cycle it is 0.
- R3: Command 8'h35 sets `quad_mode` to 1, but only when `quad_mode` is 0. When `quad_mode` is already 1, the command changes nothing.
- R4: Command 8'hF5 clears `quad_mode`, but only when `quad_mode` is 1. In serial mode it changes nothing.
- R5: Command 8'hC0 inverts `wrap_mode` (0 = linear, 1 = 32-byte wrap). It works in either mode.
- R6: Command 8'h99 that directly follows 8'h66 makes `soft_rst` 1 for one cycle, together with `cmd_ack`. In that same cycle `quad_mode` and `wrap_mode` become 0.
- R7: Command 8'h99 without a directly preceding 8'h66 changes nothing. Any other accepted command after 8'h66 cancels the armed reset. This includes commands that are themselves ignored. A repeated 8'h66 keeps the tracker armed.
- R8: After a reset, the commands at the next `RST_CYC` clock edges are not acknowledged and change no state. A command at the edge after that window is accepted.
- R9: Clock cycles with `cmd_vld` low do not cancel an armed reset and change no state.
- R10: Any command value other than 8'h35, 8'hF5, 8'hC0, 8'h66 and 8'h99 is acknowledged and leaves both mode bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | One-cycle strobe: a new command byte is present |
| cmd_byte | input | 8 | Command value captured at chip-select fall |
| quad_mode | output | 1 | 1 = quad mode, 0 = serial mode |
| wrap_mode | output | 1 | 1 = 32-byte wrapped burst, 0 = linear burst |
| soft_rst | output | 1 | One-cycle software reset pulse |
| cmd_ack | output | 1 | One-cycle pulse: command accepted |

## Verification
The assertions check these properties on every cycle:
- A mode bit never changes without an acknowledge.
- A reset pulse always comes with cleared mode bits and with an acknowledge.
- No acknowledge appears in a cycle without a command.
- No acknowledge appears inside the quiet window that follows a reset.

Some behaviour only the bench's scenarios can show, because it depends on the command history. This covers whether a reset fires or is cancelled by an intervening command, the exact length of the quiet window and the first accepted command after it, and the mode-dependent ignoring of 8'h35 and 8'hF5.

// File: rtl/psram_cmd_tracker.sv
module psram_cmd_tracker #(
  parameter int RST_CYC = 13,
  parameter logic [7:0] OP_RSTEN = 8'h66,
  parameter logic [7:0] OP_RST   = 8'h99,
  parameter logic [7:0] OP_QUAD  = 8'h35,
  parameter logic [7:0] OP_SER   = 8'hF5,
  parameter logic [7:0] OP_WRAP  = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_vld,
  input  logic [7:0] cmd_byte,
  output logic       quad_mode,
  output logic       wrap_mode,
  output logic       soft_rst,
  output logic       cmd_ack
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic          armed;
  logic [CW-1:0] quiet;
  logic          take, fire;

  assign take = cmd_vld && (quiet == '0);
  assign fire = take && armed && (cmd_byte == OP_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_mode <= 1'b0;
      wrap_mode <= 1'b0;
      armed     <= 1'b0;
      soft_rst  <= 1'b0;
      cmd_ack   <= 1'b0;
      quiet     <= '0;
    end else begin
      soft_rst <= fire;
      cmd_ack  <= take;
      if (quiet != '0) quiet <= quiet - 1'b1;
      if (take) begin
        armed <= (cmd_byte == OP_RSTEN);
        if (fire) begin
          quad_mode <= 1'b0;
          wrap_mode <= 1'b0;
          quiet     <= CW'(RST_CYC);
        end else begin
          if (cmd_byte == OP_QUAD && !quad_mode) quad_mode <= 1'b1;
          if (cmd_byte == OP_SER  &&  quad_mode) quad_mode <= 1'b0;
          if (cmd_byte == OP_WRAP) wrap_mode <= ~wrap_mode;
        end
      end
    end
  end
endmodule

// File: rtl/psram_cmd_tracker_chk.sv
module psram_cmd_tracker_chk #(
  parameter int RST_CYC = 13
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_vld,
  input logic quad_mode,
  input logic wrap_mode,
  input logic soft_rst,
  input logic cmd_ack
);
  localparam int CW = $clog2(RST_CYC + 1);
  logic [CW-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else if (soft_rst) win <= CW'(RST_CYC);
    else if (win != '0) win <= win - 1'b1;
  end

  p_rst_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!quad_mode && !wrap_mode && cmd_ack));
  p_no_ack_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !cmd_ack);
  p_quiet_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) |-> !cmd_ack);
  p_quad_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quad_mode) |-> cmd_ack);
  p_quad_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(quad_mode) |-> cmd_ack);
  p_wrap_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wrap_mode) |-> cmd_ack);
  p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);
endmodule

bind psram_cmd_tracker psram_cmd_tracker_chk #(.RST_CYC(RST_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .quad_mode(quad_mode),
  .wrap_mode(wrap_mode), .soft_rst(soft_rst), .cmd_ack(cmd_ack)
);

// File: tb/psram_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module psram_cmd_tracker_tb_top;
  localparam int RST_CYC = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_vld = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic quad_mode, wrap_mode, soft_rst, cmd_ack;

  always #2 clk = ~clk;

  psram_cmd_tracker #(.RST_CYC(RST_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
    .quad_mode(quad_mode), .wrap_mode(wrap_mode),
    .soft_rst(soft_rst), .cmd_ack(cmd_ack)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_quad = 0, m_wrap = 0, m_arm = 0, m_quiet = 0, m_ack = 0, m_rst = 0;

  task automatic check(string tag);
    n_chk++;
    if (quad_mode !== m_quad[0] || wrap_mode !== m_wrap[0] ||
        cmd_ack !== m_ack[0] || soft_rst !== m_rst[0]) begin
      n_fail++;
      $display("FAIL %s: got q=%0b w=%0b ack=%0b rst=%0b exp q=%0d w=%0d ack=%0d rst=%0d",
               tag, quad_mode, wrap_mode, cmd_ack, soft_rst, m_quad, m_wrap, m_ack, m_rst);
    end
  endtask

  task automatic step(bit v, logic [7:0] c, string tag);
    bit blocked;
    cmd_vld = v; cmd_byte = c;
    @(posedge clk);
    blocked = (m_quiet > 0);
    if (m_quiet > 0) m_quiet--;
    m_ack = 0; m_rst = 0;
    if (v && !blocked) begin
      m_ack = 1;
      if (c == 8'h99 && m_arm == 1) begin
        m_rst = 1; m_quad = 0; m_wrap = 0; m_quiet = RST_CYC;
      end else if (c == 8'h35 && m_quad == 0) m_quad = 1;
      else if (c == 8'hF5 && m_quad == 1) m_quad = 0;
      else if (c == 8'hC0) m_wrap = 1 - m_wrap;
      m_arm = (c == 8'h66) ? 1 : 0;
    end
    @(negedge clk);
    cmd_vld = 0;
    check(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    step(0, 8'h00, "R1 after reset");
    step(0, 8'h00, "R2 idle no ack");
    step(1, 8'hC0, "R5 wrap toggle serial");
    step(1, 8'h35, "R3 enter quad");
    step(1, 8'h35, "R3 enter ignored in quad");
    step(1, 8'hC0, "R5 wrap toggle quad");
    step(1, 8'hC0, "R5 wrap toggle back");
    step(1, 8'h12, "R10 unknown cmd");
    step(1, 8'hF5, "R4 exit quad");
    step(1, 8'hF5, "R4 exit ignored serial");
    step(1, 8'h99, "R7 reset without enable");
    step(1, 8'h35, "R3 enter quad again");
    step(1, 8'hC0, "R5 set wrap");
    step(1, 8'h66, "R7 arm");
    step(1, 8'hC0, "R7 cancel by other cmd");
    step(1, 8'h99, "R7 reset abandoned");
    step(1, 8'h66, "R7 arm");
    step(1, 8'h35, "R7 cancel by ignored cmd");
    step(1, 8'h99, "R7 reset abandoned after ignored");
    step(1, 8'h66, "R9 arm");
    step(0, 8'h00, "R9 idle keeps arm");
    step(0, 8'h00, "R9 idle keeps arm");
    step(1, 8'h99, "R6 reset fires");
    for (int i = 0; i < RST_CYC; i++) step(1, 8'h35, "R8 blocked in quiet");
    step(1, 8'h35, "R8 accepted after quiet");
    step(1, 8'hC0, "R5 wrap in quad");
    step(1, 8'h66, "R7 arm");
    step(1, 8'h66, "R7 rearm");
    step(1, 8'h99, "R6 reset after double enable");
    for (int i = 0; i < RST_CYC + 2; i++) step(i % 2, 8'hC0, "R8 quiet then accept");
    step(1, 8'hF5, "R4 exit ignored serial late");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule